// File: doc/BRIEF.md
# SPI Master/Slave Serial Controller

A byte-wide SPI controller behind a small register interface. Software picks master or slave operation, the clock polarity and phase, and in master mode the bit rate. Writing a byte to the data register starts a frame. The frame is eight bits long and is sent most significant bit first, and the controller receives a byte during the same frame. When the frame completes, a done flag is set and the received byte is held in a buffer. An interrupt is raised if both of its enable bits are set. The flag clears only after a status read is followed by a data read. While the flag is set and that status read has not yet happened, writes to the data register are dropped.

In master mode the block drives SCK and MOSI and samples MISO. If the slave-select input is seen low while the block is a master, the block returns to slave operation. In slave mode the block follows an external SCK, and only while slave-select is low. It reads MOSI and drives MISO. SCK, slave-select, MOSI and MISO each pass through a two-stage synchronizer. The system clock must therefore run at least four times faster than SCK.

Top module: `spi_serial_ctrl`

## Requirements
- R1: After reset, all registers read 0, the done flag is clear, and sck_o, irq_o and every output enable are 0.
- R2: Register addresses. Address 0 is control: bits [1:0] rate, bit 2 phase, bit 3 polarity, bit 4 master, bit 5 output enable, bit 6 interrupt enable. Address 1 is status, with bit 7 the done flag. Address 2 is the 8-bit prescaler. Address 3 is data. Address 4 is auxiliary: bit 0 divide-by-2, bit 1 interrupt select. The control, prescaler and auxiliary registers read back what was written.
- R3: In master mode every SCK half period lasts (prescaler+1) × 2^(rate + divide-by-2) system clocks.
- R4: Each frame moves 8 bits, most significant bit first. A read of the data register returns the byte received in the last completed frame.
- R5: SCK idles at the polarity level. With phase 0, data is sampled on the first, third and following odd edges of SCK and changes on the even edges. With phase 1, data changes on the odd edges and is sampled on the even edges. The first bit is valid before the first edge.
- R6: The done flag (status bit 7) is set when a frame completes. irq_o is 1 only while the flag, the interrupt enable and the interrupt select are all 1.
- R7: The done flag clears only when a status read that sees the flag set is followed by a data read. A data read on its own leaves the flag set.
- R8: A data write is dropped, and no frame starts, if it arrives while the done flag is set and not yet armed by a status read, or while a frame is in progress.
- R9: If slave-select is low while the master bit is set, the master and output-enable bits clear. Any frame in progress is abandoned: SCK returns to idle and the done flag is not set.
- R10: In slave mode, shifting follows the external SCK while slave-select is low. The prescaler, rate and divide-by-2 settings have no effect. SCK edges seen while slave-select is high are ignored.
- R11: sck_oe_o and mosi_oe_o equal master AND output enable. miso_oe_o is 1 only in slave mode, with output enable set and slave-select low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (drives the clear sequence) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock when master |
| sck_oe_o | output | 1 | Enable for the sck_o output |
| ss_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data in (slave mode) |
| mosi_o | output | 1 | Serial data out (master mode) |
| mosi_oe_o | output | 1 | Enable for the mosi_o output |
| miso_i | input | 1 | Serial data in (master mode) |
| miso_o | output | 1 | Serial data out (slave mode) |
| miso_oe_o | output | 1 | Enable for the miso_o output |
| irq_o | output | 1 | Frame-complete interrupt |

## Verification
The bench runs a frame in master mode and in slave mode for each of the four polarity and phase combinations. It uses asymmetric bytes in both directions, so a design that sends LSB first, samples on the wrong edge or leaves SCK off its idle level returns a wrong byte. The bench measures SCK half periods for two divider settings, which catches an off-by-one count or a wrong shift in the rate. It also tests the clear sequence: a data read without a status read must leave the interrupt up, and a write made while the flag is set must not produce any SCK edge. A design that accepted writes too early would show extra edges or a corrupted byte. A slave-select pull-down in the middle of a frame must abort the frame and set no flag.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
  localparam int ADDR_W = 3;
  localparam int RATE_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 3'd0,
    REG_STAT  = 3'd1,
    REG_PRESC = 3'd2,
    REG_DATA  = 3'd3,
    REG_AUX   = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic              irq_en;
    logic              out_en;
    logic              master;
    logic              cpol;
    logic              cpha;
    logic [RATE_W-1:0] rate;
  } ctrl_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int PRE_W  = 8,
  parameter int RS_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] presc_i,
  input  logic [RS_W-1:0]  rate_i,
  input  logic             div2_i,
  output logic             tick_o
);
  localparam int SH_MAX = 1 << RS_W;
  localparam int CNT_W  = PRE_W + 1 + SH_MAX;

  logic [CNT_W-1:0] base, lim, cnt_q;
  logic [RS_W:0]    shamt;

  always_comb begin
    base  = CNT_W'(presc_i) + CNT_W'(1);
    shamt = {1'b0, rate_i} + {{RS_W{1'b0}}, div2_i};
    lim   = base << shamt;
  end

  assign tick_o = run_i && (cnt_q == lim - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              edge_i,
  input  logic              cpha_i,
  input  logic              in_bit_i,
  output logic              out_bit_o,
  output logic              active_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int EDGES = 2 * DATA_W;
  localparam int CNT_W = $clog2(EDGES + 1);

  logic [CNT_W-1:0]  cnt_q, nth;
  logic [DATA_W-1:0] tx_q, rx_q, rx_nxt;
  logic              odd, smp, shf;

  always_comb begin
    nth    = cnt_q + CNT_W'(1);
    odd    = nth[0];
    smp    = edge_i && (odd != cpha_i);
    // phase 1: first leading edge only presents the MSB already on the line
    shf    = edge_i && (odd == cpha_i) &&
             (cpha_i ? (nth != CNT_W'(1)) : (nth != CNT_W'(EDGES)));
    done_o = edge_i && (nth == CNT_W'(EDGES));
    rx_nxt = {rx_q[DATA_W-2:0], in_bit_i};
    rx_o   = smp ? rx_nxt : rx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
    end else begin
      if (clr_i || done_o) cnt_q <= '0;
      else if (edge_i)     cnt_q <= nth;
      if (load_i)          tx_q  <= load_data_i;
      else if (shf)        tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
      if (smp)             rx_q  <= rx_nxt;
    end
  end

  assign out_bit_o = tx_q[DATA_W-1];
  assign active_o  = (cnt_q != '0);

  assert_load_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (cnt_q == '0));
endmodule

// File: rtl/spi_serial_ctrl.sv
module spi_serial_ctrl
  import spi_ctrl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              ss_ni,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              irq_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic              sck_s, ss_s, mosi_s, miso_s, sck_d;
  ctrl_t             ctrl_q;
  logic [PRE_W-1:0]  presc_q;
  logic              div2_q, irq_sel_q;
  logic              flag_q, armed_q, busy_q, sck_q;
  logic [DATA_W-1:0] rx_buf_q, sh_rx;
  logic              tick, sh_edge, sh_done, sh_active, sh_out, sh_in, sh_clr;
  logic              wr_ctrl, wr_data, wr_presc, wr_aux, rd_stat, rd_data;
  logic              fault, wr_ok, load, start;

  spi_sync #(.W(4), .RST_VAL(4'b0100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, ss_ni, mosi_i, miso_i}),
    .q_o   ({sck_s, ss_s, mosi_s, miso_s})
  );

  always_comb begin
    wr_ctrl  = wr_i && (addr_i == REG_CTRL);
    wr_data  = wr_i && (addr_i == REG_DATA);
    wr_presc = wr_i && (addr_i == REG_PRESC);
    wr_aux   = wr_i && (addr_i == REG_AUX);
    rd_stat  = rd_i && (addr_i == REG_STAT);
    rd_data  = rd_i && (addr_i == REG_DATA);
    fault    = ctrl_q.master && !ss_s;
    wr_ok    = (!flag_q || armed_q) && (ctrl_q.master ? !busy_q : !sh_active);
    load     = wr_data && wr_ok && !fault;
    start    = load && ctrl_q.master;
    sh_edge  = ctrl_q.master ? (busy_q && tick) : (!ss_s && (sck_s ^ sck_d));
    sh_clr   = ctrl_q.master ? fault : ss_s;
    sh_in    = ctrl_q.master ? miso_s : mosi_s;
  end

  spi_baud_gen #(.PRE_W(PRE_W), .RS_W(RATE_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q),
    .presc_i(presc_q),
    .rate_i (ctrl_q.rate),
    .div2_i (div2_q),
    .tick_o (tick)
  );

  spi_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (sh_clr),
    .load_i     (load),
    .load_data_i(wdata_i),
    .edge_i     (sh_edge),
    .cpha_i     (ctrl_q.cpha),
    .in_bit_i   (sh_in),
    .out_bit_o  (sh_out),
    .active_o   (sh_active),
    .done_o     (sh_done),
    .rx_o       (sh_rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      presc_q   <= '0;
      div2_q    <= 1'b0;
      irq_sel_q <= 1'b0;
      sck_d     <= 1'b0;
    end else begin
      sck_d <= sck_s;
      if (wr_ctrl)  ctrl_q  <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_presc) presc_q <= wdata_i[PRE_W-1:0];
      if (wr_aux) begin
        div2_q    <= wdata_i[0];
        irq_sel_q <= wdata_i[1];
      end
      if (fault) begin
        ctrl_q.master <= 1'b0;
        ctrl_q.out_en <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
    end else begin
      if (fault)                          busy_q <= 1'b0;
      else if (start)                     busy_q <= 1'b1;
      else if (sh_done && ctrl_q.master)  busy_q <= 1'b0;
      if (!busy_q)   sck_q <= ctrl_q.cpol;
      else if (tick) sck_q <= ~sck_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= 1'b0;
      armed_q  <= 1'b0;
      rx_buf_q <= '0;
    end else if (sh_done) begin
      flag_q   <= 1'b1;
      armed_q  <= 1'b0;
      rx_buf_q <= sh_rx;
    end else begin
      if (rd_stat && flag_q) armed_q <= 1'b1;
      if (rd_data && armed_q) begin
        flag_q  <= 1'b0;
        armed_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_CTRL:  rdata_o = DATA_W'(ctrl_q);
      REG_STAT:  rdata_o = {flag_q, {(DATA_W-1){1'b0}}};
      REG_PRESC: rdata_o = DATA_W'(presc_q);
      REG_DATA:  rdata_o = rx_buf_q;
      REG_AUX:   rdata_o = DATA_W'({irq_sel_q, div2_q});
      default:   rdata_o = '0;
    endcase
  end

  assign sck_o     = sck_q;
  assign sck_oe_o  = ctrl_q.master && ctrl_q.out_en;
  assign mosi_o    = ctrl_q.master && sh_out;
  assign mosi_oe_o = ctrl_q.master && ctrl_q.out_en;
  assign miso_o    = !ctrl_q.master && sh_out;
  assign miso_oe_o = !ctrl_q.master && ctrl_q.out_en && !ss_s;
  assign irq_o     = flag_q && ctrl_q.irq_en && irq_sel_q;

  assert_mode_fault_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.master && !ss_s) |=> (!ctrl_q.master && !ctrl_q.out_en));

  assert_write_inhibit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && flag_q && !armed_q && ctrl_q.master && !busy_q) |=> !busy_q);

  assert_clear_seq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> ($past(armed_q) && $past(rd_i)));

  assert_sck_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_done && ctrl_q.master) |=> (sck_q == ctrl_q.cpol));

  assert_irq_raise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_done && ctrl_q.irq_en && irq_sel_q) |=> irq_o);
endmodule

// File: tb/sim_spi_serial_ctrl.sv
module sim_spi_serial_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sck_in = 1'b0, ss_n = 1'b1, mosi_in = 1'b0;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, irq;
  wire        miso_in;

  int total = 0, bad = 0;
  int sck_edges = 0;

  // bench slave model for master-mode frames
  logic       bm_on = 1'b0, bm_cpha = 1'b0;
  int         bm_e = 0, bm_idx = 0;
  logic [7:0] bm_got = '0, bm_tx = '0;
  assign miso_in = (bm_idx < 8) ? bm_tx[7 - bm_idx] : 1'b0;

  always #5 clk = ~clk;

  spi_serial_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .sck_i(sck_in), .sck_o(sck_o),
    .sck_oe_o(sck_oe), .ss_ni(ss_n), .mosi_i(mosi_in), .mosi_o(mosi_o),
    .mosi_oe_o(mosi_oe), .miso_i(miso_in), .miso_o(miso_o),
    .miso_oe_o(miso_oe), .irq_o(irq)
  );

  always @(sck_o) begin
    sck_edges++;
    if (bm_on) begin
      bm_e++;
      if (((bm_e % 2) == 1) != bm_cpha) bm_got = {bm_got[6:0], mosi_o};
      else if (!(bm_cpha && bm_e == 1)) bm_idx++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_flag(output logic [7:0] st);
    st = '0;
    for (int i = 0; i < 400 && !st[7]; i++) cpu_rd(3'd1, st);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    cpu_rd(3'd0, d); chk("R1 ctrl", d, 0);
    cpu_rd(3'd1, d); chk("R1 status", d, 0);
    cpu_rd(3'd2, d); chk("R1 presc", d, 0);
    cpu_rd(3'd4, d); chk("R1 aux", d, 0);
    chk("R1 sck/irq/oe", {sck_o, irq, sck_oe, mosi_oe, miso_oe}, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    cpu_wr(3'd0, 8'h7F); cpu_rd(3'd0, d); chk("R2 ctrl readback", d, 8'h7F);
    chk("R11 master oe", {sck_oe, mosi_oe, miso_oe}, 3'b110);
    cpu_wr(3'd2, 8'hA5); cpu_rd(3'd2, d); chk("R2 presc readback", d, 8'hA5);
    cpu_wr(3'd4, 8'h03); cpu_rd(3'd4, d); chk("R2 aux readback", d, 8'h03);
    cpu_wr(3'd0, 8'h00); cpu_wr(3'd4, 8'h00);
  endtask

  task automatic master_xfer(input logic cpol, input logic cpha,
                             input logic [7:0] tx, input logic [7:0] sb);
    logic [7:0] d, st;
    cpu_wr(3'd2, 8'd3);
    cpu_wr(3'd0, {3'b011, cpol, cpha, 2'b00});
    repeat (4) @(negedge clk);
    bm_cpha = cpha; bm_e = 0; bm_idx = 0; bm_got = '0; bm_tx = sb; bm_on = 1'b1;
    cpu_wr(3'd3, tx);
    wait_flag(st);
    chk("R6 flag set", st[7], 1);
    cpu_rd(3'd3, d);
    bm_on = 1'b0;
    chk("R4 R5 mosi byte msb first", bm_got, tx);
    chk("R4 R5 received byte", d, sb);
    chk("R5 sck edges", bm_e, 16);
    chk("R5 sck idle", sck_o, cpol);
    cpu_rd(3'd1, st); chk("R7 flag cleared", st[7], 0);
  endtask

  task automatic measure_half(input logic [7:0] p, input logic div2,
                              input logic [1:0] rs, input int exp);
    logic [7:0] st, d;
    logic v;
    int n;
    cpu_wr(3'd2, p); cpu_wr(3'd4, {7'd0, div2});
    cpu_wr(3'd0, {5'b01100, rs});
    cpu_wr(3'd3, 8'h5A);
    @(sck_o);
    v = sck_o; n = 0;
    do begin @(posedge clk); #1 n++; end while (sck_o == v && n < 5000);
    chk("R3 half period", n, exp);
    wait_flag(st); cpu_rd(3'd3, d);
    cpu_wr(3'd4, 8'h00);
  endtask

  task automatic t_irq_inhibit();
    logic [7:0] d, st;
    int e0, n;
    cpu_wr(3'd2, 8'd3); cpu_wr(3'd4, 8'h02);
    cpu_wr(3'd0, 8'h70);
    repeat (4) @(negedge clk);
    bm_cpha = 1'b0; bm_e = 0; bm_idx = 0; bm_got = '0; bm_tx = 8'h39; bm_on = 1'b1;
    cpu_wr(3'd3, 8'hC6);
    repeat (10) @(negedge clk);
    cpu_wr(3'd3, 8'hFF);  // mid-frame write
    n = 0;
    while (!irq && n < 400) begin @(negedge clk); n++; end
    bm_on = 1'b0;
    chk("R6 irq raised", irq, 1);
    chk("R8 busy write ignored", bm_got, 8'hC6);
    cpu_rd(3'd3, d);
    chk("R4 rx buffer", d, 8'h39);
    @(negedge clk); chk("R7 data read alone keeps flag", irq, 1);
    e0 = sck_edges;
    cpu_wr(3'd3, 8'h11);
    repeat (80) @(negedge clk);
    chk("R8 inhibited write no sck", sck_edges - e0, 0);
    cpu_rd(3'd1, st);
    cpu_rd(3'd3, d);
    @(negedge clk); chk("R7 sequence clears irq", irq, 0);
    cpu_rd(3'd1, st); chk("R7 status after clear", st[7], 0);
    cpu_wr(3'd4, 8'h00);
    cpu_wr(3'd3, 8'h22);
    repeat (150) @(negedge clk);
    chk("R6 irq masked by select", irq, 0);
    cpu_rd(3'd1, st); chk("R6 flag without irq", st[7], 1);
    cpu_rd(3'd3, d);
  endtask

  task automatic t_fault();
    logic [7:0] d, st;
    cpu_wr(3'd2, 8'd7); cpu_wr(3'd0, 8'h30);
    repeat (4) @(negedge clk);
    cpu_wr(3'd3, 8'hAA);
    repeat (30) @(negedge clk);
    ss_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 sck idle after abort", sck_o, 0);
    cpu_rd(3'd0, d); chk("R9 master/out_en cleared", d[5:4], 0);
    chk("R11 oe after fault", {sck_oe, mosi_oe, miso_oe}, 0);
    repeat (200) @(negedge clk);
    cpu_rd(3'd1, st); chk("R9 no flag after abort", st[7], 0);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic slave_xfer(input logic cpol, input logic cpha,
                            input logic [7:0] tx, input logic [7:0] mb);
    logic [7:0] d, st, got;
    got = '0;
    cpu_wr(3'd2, 8'hFF); cpu_wr(3'd4, 8'h01);
    cpu_wr(3'd0, {3'b010, cpol, cpha, 2'b11});
    cpu_wr(3'd3, tx);
    sck_in = cpol;
    repeat (4) @(negedge clk);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 slave miso oe", {miso_oe, sck_oe, mosi_oe}, 3'b100);
    for (int b = 7; b >= 0; b--) begin
      if (!cpha) mosi_in = mb[b];
      repeat (8) @(negedge clk);
      sck_in = ~sck_in;
      if (cpha) mosi_in = mb[b];
      else got = {got[6:0], miso_o};
      repeat (8) @(negedge clk);
      sck_in = ~sck_in;
      if (cpha) got = {got[6:0], miso_o};
    end
    repeat (6) @(negedge clk);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 R4 slave miso byte", got, tx);
    cpu_rd(3'd1, st); chk("R10 slave flag", st[7], 1);
    cpu_rd(3'd3, d); chk("R10 slave received byte", d, mb);
  endtask

  task automatic t_slave_ignore();
    logic [7:0] st;
    cpu_wr(3'd0, 8'h20);
    ss_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      repeat (8) @(negedge clk);
      sck_in = ~sck_in;
    end
    repeat (8) @(negedge clk);
    cpu_rd(3'd1, st); chk("R10 edges with ss high ignored", st[7], 0);
    chk("R11 miso oe with ss high", miso_oe, 0);
    cpu_wr(3'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    master_xfer(1'b0, 1'b0, 8'hA5, 8'h3C);
    master_xfer(1'b0, 1'b1, 8'h96, 8'hC3);
    master_xfer(1'b1, 1'b0, 8'h81, 8'h7E);
    master_xfer(1'b1, 1'b1, 8'h4B, 8'hD2);
    measure_half(8'd1, 1'b1, 2'd1, 8);
    measure_half(8'd2, 1'b0, 2'd2, 12);
    t_irq_inhibit();
    t_fault();
    slave_xfer(1'b0, 1'b0, 8'hB1, 8'h4E);
    slave_xfer(1'b0, 1'b1, 8'h1D, 8'hE2);
    slave_xfer(1'b1, 1'b0, 8'hC5, 8'h3A);
    slave_xfer(1'b1, 1'b1, 8'h6F, 8'h90);
    t_slave_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule